// File: doc/BRIEF.md
# Frequency Window Lock Detector

This block supervises the frequency of a clock and data recovery oscillator. It runs off the reference clock and counts rising edges of the divided oscillator clock over a gate interval of a programmable number of reference cycles. At the end of each gate the count is brought into the reference domain through a toggle handshake with two-flop synchronizers on both sides. The count is then compared with a window that software sets as an expected count and a half-width in counts. For a ±1000 ppm window against a 19.44 MHz reference, software sets the half-width to about one thousandth of the expected count.

While the oscillator is outside the window, the block stays in acquisition. The phase detector enable is held low and a slow-down or speed-up command steers the oscillator toward the target. After two consecutive measurements inside the window, it raises the in-window flag and releases the phase detector. The measurement keeps running after lock, and two consecutive outside measurements return the block to acquisition with steering active again. This requirement for two in a row keeps a result that sits on a window edge from toggling the state on every gate.

Top module: `fwd_lock_detector`

## Requirements
- R1: A synchronous active-high `rst` puts the block in acquisition with `in_window`, `pd_enable`, `slow_down` and `speed_up` all low. Reset must be held for at least four cycles of each clock.
- R2: A measurement is the number of rising edges of `osc_div_clk` within one gate of `gate_cycles` reference cycles (values below 16 act as 16). The first measurement after reset is discarded. Outputs change only on the reference cycle after a measurement is accepted, or through reset.
- R3: A measurement is inside when `expected_cnt - half_width <= count <= expected_cnt + half_width`. Both bounds are inclusive, and the lower bound clamps at zero.
- R4: In acquisition, two consecutive inside measurements set `in_window` and `pd_enable` high. An inside measurement followed by an outside one does not lock.
- R5: While locked, a single outside measurement changes no output. Two consecutive outside measurements clear `in_window` and `pd_enable`.
- R6: In acquisition, a measurement above the upper bound gives `slow_down`=1 and `speed_up`=0. One below the lower bound gives `speed_up`=1 and `slow_down`=0. An inside measurement clears both. The two are never high together.
- R7: While `in_window` is high, `slow_down` and `speed_up` are both low.
- R8: `pd_enable` equals `in_window` at every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control logic and outputs |
| rst | input | 1 | Synchronous active-high reset (reference domain) |
| osc_div_clk | input | 1 | Divided oscillator clock being measured |
| gate_cycles | input | GATE_W | Gate length in reference cycles |
| expected_cnt | input | CNT_W | Target edge count per gate |
| half_width | input | CNT_W | Window half-width in counts |
| in_window | output | 1 | Frequency lock status |
| pd_enable | output | 1 | Enable for the data phase detector |
| slow_down | output | 1 | Steer oscillator lower |
| speed_up | output | 1 | Steer oscillator higher |

## Verification
Each gate ends a measurement. The outputs reflect it about eight reference cycles later, after the oscillator-side synchronizer, the return synchronizer, the capture register and the state register. So the bench measures every wait in whole gates and samples at falling edges well clear of that latency. After reset, lock is due right after the third gate closes. For this reason the bench checks at gate 2.5 (still unlocked, which shows the discarded first sample) and at gate 3.5 (locked). For single-sample and double-sample hysteresis the bench leaves the oscillator alone and moves the window for exactly one or two gate lengths. Since accepted measurements arrive once per gate, such an edit covers exactly that many of them.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [0:0] {
        ST_ACQ   = 1'b0,
        ST_TRACK = 1'b1
    } fwd_state_e;

    typedef enum logic [1:0] {
        CLS_IN = 2'd0,
        CLS_HI = 2'd1,
        CLS_LO = 2'd2
    } fwd_cls_e;

endpackage

// File: rtl/fwd_gate_timer.sv
module fwd_gate_timer #(
    parameter int GATE_W   = 16,
    parameter int MIN_GATE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GATE_W-1:0] gate_cycles,
    output logic              req_tgl
);
    localparam logic [GATE_W-1:0] MIN_LEN = GATE_W'(MIN_GATE);

    typedef struct packed {
        logic [GATE_W-1:0] cnt;
        logic              tgl;
    } gt_t;

    gt_t q, d;
    logic [GATE_W-1:0] eff_len;

    always_comb begin
        eff_len = (gate_cycles < MIN_LEN) ? MIN_LEN : gate_cycles;
        d = q;
        if (rst) begin
            d.cnt = '0;
            d.tgl = 1'b0;
        end else if (q.cnt >= eff_len - GATE_W'(1)) begin
            d.cnt = '0;
            d.tgl = ~q.tgl;
        end else begin
            d.cnt = q.cnt + GATE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign req_tgl = q.tgl;

endmodule

// File: rtl/fwd_osc_counter.sv
module fwd_osc_counter #(
    parameter int CNT_W = 16,
    parameter int SYNC  = 2
) (
    input  logic             osc_clk,
    input  logic             rst,
    input  logic             req_tgl,
    output logic [CNT_W-1:0] hold_cnt,
    output logic             ack_tgl
);
    localparam int RS_W = SYNC;
    localparam int RQ_W = SYNC + 1;

    typedef struct packed {
        logic [RS_W-1:0]  rst_s;
        logic [RQ_W-1:0]  req_s;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             ack;
    } oc_t;

    oc_t q, d;
    logic req_edge;
    logic rst_osc;

    always_comb begin
        rst_osc  = q.rst_s[RS_W-1];
        req_edge = q.req_s[RQ_W-1] ^ q.req_s[RQ_W-2];
        d        = q;
        d.rst_s  = {q.rst_s[RS_W-2:0], rst};
        d.req_s  = {q.req_s[RQ_W-2:0], req_tgl};
        if (rst_osc) begin
            d.cnt  = '0;
            d.hold = '0;
            d.ack  = 1'b0;
        end else if (req_edge) begin
            d.hold = q.cnt;
            d.cnt  = CNT_W'(1);
            d.ack  = ~q.ack;
        end else if (q.cnt != '1) begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge osc_clk) begin
        q <= d;
    end

    assign hold_cnt = q.hold;
    assign ack_tgl  = q.ack;

endmodule

// File: rtl/fwd_window_cmp.sv
module fwd_window_cmp
    import fwd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] expected,
    input  logic [CNT_W-1:0] half,
    output fwd_cls_e         cls
);
    logic [CNT_W:0]   upper;
    logic [CNT_W-1:0] lower;

    always_comb begin
        upper = {1'b0, expected} + {1'b0, half};
        lower = (expected >= half) ? (expected - half) : '0;
        if ({1'b0, count} > upper) begin
            cls = CLS_HI;
        end else if (count < lower) begin
            cls = CLS_LO;
        end else begin
            cls = CLS_IN;
        end
    end

endmodule

// File: rtl/fwd_lock_detector.sv
module fwd_lock_detector
    import fwd_pkg::*;
#(
    parameter int GATE_W = 16,
    parameter int CNT_W  = 16,
    parameter int HYST   = 2
) (
    input  logic              ref_clk,
    input  logic              rst,
    input  logic              osc_div_clk,
    input  logic [GATE_W-1:0] gate_cycles,
    input  logic [CNT_W-1:0]  expected_cnt,
    input  logic [CNT_W-1:0]  half_width,
    output logic              in_window,
    output logic              pd_enable,
    output logic              slow_down,
    output logic              speed_up
);
    localparam int SW = (HYST > 1) ? $clog2(HYST) : 1;
    localparam logic [SW-1:0] LAST = SW'(HYST - 1);

    typedef struct packed {
        fwd_state_e       state;
        logic [SW-1:0]    streak;
        logic             slow;
        logic             fast;
        logic [CNT_W-1:0] meas;
        logic             meas_vld;
        logic             primed;
        logic [2:0]       ack_s;
    } ctl_t;

    ctl_t q, d;

    logic             req_tgl;
    logic             ack_tgl;
    logic [CNT_W-1:0] hold_cnt;
    fwd_cls_e         cls;
    logic             ack_edge;
    logic             meas_vld;
    logic [1:0]       cls_bits;

    fwd_gate_timer #(.GATE_W(GATE_W)) u_gate (
        .clk         (ref_clk),
        .rst         (rst),
        .gate_cycles (gate_cycles),
        .req_tgl     (req_tgl)
    );

    fwd_osc_counter #(.CNT_W(CNT_W)) u_cnt (
        .osc_clk  (osc_div_clk),
        .rst      (rst),
        .req_tgl  (req_tgl),
        .hold_cnt (hold_cnt),
        .ack_tgl  (ack_tgl)
    );

    fwd_window_cmp #(.CNT_W(CNT_W)) u_cmp (
        .count    (q.meas),
        .expected (expected_cnt),
        .half     (half_width),
        .cls      (cls)
    );

    always_comb begin
        ack_edge   = q.ack_s[2] ^ q.ack_s[1];
        d          = q;
        d.ack_s    = {q.ack_s[1:0], ack_tgl};
        d.meas_vld = 1'b0;
        if (rst) begin
            d.state  = ST_ACQ;
            d.streak = '0;
            d.slow   = 1'b0;
            d.fast   = 1'b0;
            d.meas   = '0;
            d.primed = 1'b0;
        end else begin
            if (ack_edge) begin
                d.primed   = 1'b1;
                d.meas_vld = q.primed;
                d.meas     = hold_cnt;
            end
            if (q.meas_vld) begin
                case (q.state)
                    ST_ACQ: begin
                        if (cls == CLS_IN) begin
                            d.slow = 1'b0;
                            d.fast = 1'b0;
                            if (q.streak == LAST) begin
                                d.state  = ST_TRACK;
                                d.streak = '0;
                            end else begin
                                d.streak = q.streak + SW'(1);
                            end
                        end else begin
                            d.slow   = (cls == CLS_HI);
                            d.fast   = (cls == CLS_LO);
                            d.streak = '0;
                        end
                    end
                    default: begin
                        if (cls == CLS_IN) begin
                            d.streak = '0;
                        end else if (q.streak == LAST) begin
                            d.state  = ST_ACQ;
                            d.streak = '0;
                            d.slow   = (cls == CLS_HI);
                            d.fast   = (cls == CLS_LO);
                        end else begin
                            d.streak = q.streak + SW'(1);
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge ref_clk) begin
        q <= d;
    end

    assign meas_vld  = q.meas_vld;
    assign cls_bits  = cls;
    assign in_window = (q.state == ST_TRACK);
    assign pd_enable = (q.state == ST_TRACK);
    assign slow_down = q.slow;
    assign speed_up  = q.fast;

endmodule

// File: rtl/fwd_lock_checker.sv
module fwd_lock_checker (
    input logic       clk,
    input logic       rst,
    input logic       meas_vld,
    input logic [1:0] cls,
    input logic       in_window,
    input logic       pd_enable,
    input logic       slow_down,
    input logic       speed_up
);
    logic [1:0] in_run_q;
    logic [1:0] out_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_run_q  <= '0;
            out_run_q <= '0;
        end else if (meas_vld) begin
            if (cls == 2'd0) begin
                in_run_q  <= (in_run_q == 2'd3) ? 2'd3 : in_run_q + 2'd1;
                out_run_q <= '0;
            end else begin
                out_run_q <= (out_run_q == 2'd3) ? 2'd3 : out_run_q + 2'd1;
                in_run_q  <= '0;
            end
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!in_window && !pd_enable && !slow_down && !speed_up));

    assert_update_on_measure_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(meas_vld) && !$past(rst))
            |-> $stable({in_window, pd_enable, slow_down, speed_up}));

    assert_lock_needs_two_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(in_window) |-> (in_run_q >= 2'd2));

    assert_unlock_needs_two_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(in_window) |-> (out_run_q >= 2'd2));

    assert_never_both_steer_R6: assert property (@(posedge clk) disable iff (rst)
        !(slow_down && speed_up));

    assert_quiet_when_locked_R7: assert property (@(posedge clk) disable iff (rst)
        in_window |-> (!slow_down && !speed_up));

    assert_pd_matches_flag_R8: assert property (@(posedge clk) disable iff (rst)
        pd_enable == in_window);

endmodule

bind fwd_lock_detector fwd_lock_checker u_chk (
    .clk       (ref_clk),
    .rst       (rst),
    .meas_vld  (meas_vld),
    .cls       (cls_bits),
    .in_window (in_window),
    .pd_enable (pd_enable),
    .slow_down (slow_down),
    .speed_up  (speed_up)
);

// File: tb/sim_fwd_lock_detector.sv
`timescale 1ns/1ps
module sim_fwd_lock_detector;
    localparam int G = 64;

    typedef struct packed {
        logic [7:0]  half_ns;
        logic [15:0] expd;
        logic [15:0] hw;
        logic [3:0]  want;
    } vec_t;

    // want = {in_window, pd_enable, slow_down, speed_up}
    // osc half period 4 ns -> 80 edges per gate, 5 ns -> 64, 3 ns -> ~106
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'd4, 16'd80, 16'd4,   4'b1100},  // R4 lock at nominal
        '{8'd3, 16'd80, 16'd4,   4'b0010},  // R5 R6 fast osc -> slow_down
        '{8'd5, 16'd80, 16'd4,   4'b0001},  // R6 slow osc -> speed_up
        '{8'd4, 16'd80, 16'd4,   4'b1100},  // R4 relock
        '{8'd4, 16'd78, 16'd2,   4'b1100},  // R3 upper bound inclusive
        '{8'd4, 16'd77, 16'd2,   4'b0010},  // R3 one above upper
        '{8'd4, 16'd82, 16'd2,   4'b1100},  // R3 lower bound inclusive
        '{8'd4, 16'd83, 16'd2,   4'b0001},  // R3 one below lower
        '{8'd5, 16'd64, 16'd0,   4'b1100},  // R3 zero half-width exact
        '{8'd5, 16'd2,  16'd100, 4'b1100}   // R3 lower bound clamps at zero
    };

    logic        ref_clk = 1'b0;
    logic        osc_clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] gate_cycles = 16'(G);
    logic [15:0] expected_cnt = 16'd80;
    logic [15:0] half_width = 16'd4;
    logic        in_window, pd_enable, slow_down, speed_up;
    int          osc_half = 4;
    int          n_chk = 0;
    int          n_fail = 0;

    fwd_lock_detector u0 (
        .ref_clk      (ref_clk),
        .rst          (rst),
        .osc_div_clk  (osc_clk),
        .gate_cycles  (gate_cycles),
        .expected_cnt (expected_cnt),
        .half_width   (half_width),
        .in_window    (in_window),
        .pd_enable    (pd_enable),
        .slow_down    (slow_down),
        .speed_up     (speed_up)
    );

    always #5 ref_clk = ~ref_clk;

    initial begin
        #0.5;
        forever #(osc_half) osc_clk = ~osc_clk;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic check(input string req, input logic [3:0] want);
        logic [3:0] got;
        got = {in_window, pd_enable, slow_down, speed_up};
        n_chk++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: outputs {in,pd,slow,fast} actual=%b expected=%b", req, got, want);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge ref_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic bad;
        wait_cyc(20);
        check("R1 during reset", 4'b0000);
        rst = 1'b0;
        wait_cyc(1);
        check("R1 after release", 4'b0000);
        // lock is due just after the third gate closes (first sample dropped)
        wait_cyc(2 * G + G / 2 - 1);
        check("R2 first sample discarded", 4'b0000);
        wait_cyc(G);
        check("R4 locked after two inside", 4'b1100);

        for (int i = 0; i < NV; i++) begin
            osc_half     = int'(VECS[i].half_ns);
            expected_cnt = VECS[i].expd;
            half_width   = VECS[i].hw;
            wait_cyc(6 * G);
            check($sformatf("R3/R4/R5/R6/R7 vector %0d", i), VECS[i].want);
            n_chk++;
            if (pd_enable !== in_window) begin
                n_fail++;
                $display("FAIL R8 vector %0d: pd_enable actual=%b expected=%b", i, pd_enable, in_window);
            end
        end

        osc_half = 4; expected_cnt = 16'd80; half_width = 16'd4;
        wait_cyc(6 * G);
        check("R4 locked before hysteresis", 4'b1100);

        // R5 R7: exactly one outside measurement while locked
        expected_cnt = 16'd200;
        bad = 1'b0;
        for (int c = 0; c < G; c++) begin
            wait_cyc(1);
            if ({in_window, pd_enable, slow_down, speed_up} !== 4'b1100) bad = 1'b1;
        end
        expected_cnt = 16'd80;
        n_chk++;
        if (bad) begin
            n_fail++;
            $display("FAIL R5 R7 single outlier: outputs left lock actual=1 expected=0");
        end
        wait_cyc(2 * G);
        check("R5 still locked after outlier", 4'b1100);

        // R5 R6: exactly two outside measurements
        expected_cnt = 16'd200;
        wait_cyc(2 * G);
        check("R5 R6 drop after two outside", 4'b0001);

        // R4: inside, outside, inside in acquisition must not lock
        expected_cnt = 16'd80;
        wait_cyc(G);
        expected_cnt = 16'd200;
        wait_cyc(G);
        expected_cnt = 16'd80;
        wait_cyc(G);
        check("R4 broken streak stays unlocked", 4'b0000);
        wait_cyc(G);
        check("R4 locks on second consecutive", 4'b1100);

        // R1: reset in the middle of lock
        rst = 1'b1;
        wait_cyc(1);
        check("R1 mid-run reset clears", 4'b0000);
        wait_cyc(10);
        rst = 1'b0;
        wait_cyc(4 * G);
        check("R4 relock after reset", 4'b1100);

        finish_run();
    end

endmodule